// File: doc/BRIEF.md
# Key cache command engine

This block keeps a small cache of media encryption keys behind a 32-bit register bus. Software fills three staging arrays (a 512-bit key, a 160-bit metadata tag and 256 bits of auxiliary data). It then starts a command by writing the control register. Three commands exist. The first stores the staged key and auxiliary data under the staged tag. The second drops the entry that carries the staged tag. The third wipes the whole cache.

Completion is signalled in the control register. Execute is cleared, done is set, the command field is kept and an error code is reported. The register then holds that value until software acknowledges it. A combinational lookup port serves the encryption datapath: it presents a tag and receives the matching key and auxiliary data.

Top module: `keycache_engine`

## Requirements
- R1: Control register bit 31 (ready) reads as 1 at all times, and right after reset the control register reads 0x8000_0000.
- R2: Control fields are: bit 0 execute, bit 1 done, bits 5:2 command, bits 19:16 error. A write that sets execute while the engine is idle is captured on that write's clock edge. On the second rising edge after that write, the register reads ready=1, error, command (unchanged), done=1 and execute=0.
- R3: Command 1 (load) stores the staged key and auxiliary words in an entry tagged by the staged metadata words, and reports error 0. Staging word i of each array maps to bits 32i+31:32i. The arrays sit at byte offsets 0x200 (16 key words), 0x240 (5 tag words) and 0x260 (8 auxiliary words). The control register is at 0x280.
- R4: Loading a tag that is already cached overwrites that entry, reports error 0 and takes no new entry, including when the cache is full.
- R5: Loading a new tag when all NUM_ENTRIES entries are valid reports error 2 and changes no entry.
- R6: Command 2 (unload) removes the entry whose tag equals the staged tag and frees it for a later load. It reports error 0, whether or not a match existed.
- R7: Command 3 (zeroize) invalidates every entry, writes zeros over all stored tag, key and auxiliary bits, and reports error 0.
- R8: Any other command code with execute set (0, 4 to 15) reports error 1 and leaves the cache unchanged.
- R9: While a completion is held, a control write is taken as acknowledgement only if it has bit 1 set and differs from the held value. The register then returns to 0x8000_0000 and no command starts.
- R10: While a command is executing or a completion is held, every control write other than an acknowledgement is ignored, and no new command starts.
- R11: Key staging words read as zero. Tag and auxiliary words read back what was written. Unmapped offsets, including 0x254 to 0x25F, read as zero.
- R12: Reset clears all entries and their stored bits, so no tag hits afterwards.
- R13: The lookup port raises lk_hit when a valid entry's tag equals lk_tag and then returns its key and auxiliary data. On a miss, lk_hit and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lk_tag | input | 160 | Tag to look up |
| lk_hit | output | 1 | A valid entry holds lk_tag |
| lk_key | output | 512 | Key of the hitting entry, zero on miss |
| lk_aux | output | 256 | Auxiliary data of the hitting entry, zero on miss |

## Verification
A corrupted valid bit or tag appears on the lookup port in the same cycle. It also shows up in the error code of the next load: a full cache reports 2 and a freed entry accepts a new tag. A stuck or mis-sequenced control state shows at the control register. Done either fails to rise on the second edge after the start write, or the register does not return to ready-only after a proper acknowledgement. Stale key bits left by zeroize cannot be seen at the ports, so that case is covered by a property on the stored state one cycle after the command.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 12;
  localparam int KEY_WORDS  = 16;
  localparam int TAG_WORDS  = 5;
  localparam int AUX_WORDS  = 8;
  localparam int KEY_W      = KEY_WORDS * WORD_W;
  localparam int TAG_W      = TAG_WORDS * WORD_W;
  localparam int AUX_W      = AUX_WORDS * WORD_W;

  localparam logic [ADDR_W-1:0] KEY_BASE  = 12'h200;
  localparam logic [ADDR_W-1:0] TAG_BASE  = 12'h240;
  localparam logic [ADDR_W-1:0] AUX_BASE  = 12'h260;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h280;

  localparam int EXE_BIT  = 0;
  localparam int DONE_BIT = 1;
  localparam int CMD_LSB  = 2;
  localparam int CMD_W    = 4;
  localparam int ERR_LSB  = 16;
  localparam int ERR_W    = 4;
  localparam int RDY_BIT  = 31;

  localparam logic [CMD_W-1:0] CMD_LOAD   = 4'd1;
  localparam logic [CMD_W-1:0] CMD_UNLOAD = 4'd2;
  localparam logic [CMD_W-1:0] CMD_WIPE   = 4'd3;

  localparam logic [ERR_W-1:0] ERR_NONE   = 4'd0;
  localparam logic [ERR_W-1:0] ERR_BADCMD = 4'd1;
  localparam logic [ERR_W-1:0] ERR_FULL   = 4'd2;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_EXEC = 2'd1,
    CS_ACK  = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/kc_warray.sv
module kc_warray
  import kc_pkg::*;
#(
  parameter int                WORDS    = 4,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter bit                READABLE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rdata,
  output logic [WORDS*WORD_W-1:0]  flat_o
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * WORDS);

  logic [ADDR_W-1:0]             offs;
  logic                          hit;
  logic [IDX_W-1:0]              idx;
  logic                          we;
  logic [WORDS-1:0][WORD_W-1:0]  mem_q, mem_d;

  // offset wraps high when addr is below BASE, so one compare covers both ends
  assign offs = addr - BASE;
  assign hit  = offs < SPAN;
  assign idx  = offs[IDX_W+1:2];
  assign we   = wr_en && hit;

  always_comb begin
    mem_d = mem_q;
    if (we) mem_d[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mem_q <= '0;
    else if (we) mem_q <= mem_d;
  end

  generate
    if (READABLE) begin : g_rd
      assign rdata = hit ? mem_q[idx] : '0;
    end else begin : g_nord
      assign rdata = '0;
    end
  endgenerate

  assign flat_o = mem_q;
endmodule

// File: rtl/kc_ctrl.sv
module kc_ctrl
  import kc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ERR_W-1:0]  res_err,
  output logic              go,
  output logic              busy_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam logic [WORD_W-1:0] RDY_ONLY = WORD_W'(1) << RDY_BIT;

  ctl_state_e        state_q, state_d;
  logic [WORD_W-1:0] ctrl_q, ctrl_d;
  logic              en;

  always_comb begin
    state_d = state_q;
    ctrl_d  = ctrl_q;
    unique case (state_q)
      CS_IDLE: begin
        if (wr_en) begin
          ctrl_d = wdata | RDY_ONLY;
          if (wdata[EXE_BIT]) state_d = CS_EXEC;
        end
      end
      CS_EXEC: begin
        ctrl_d                       = RDY_ONLY;
        ctrl_d[CMD_LSB +: CMD_W]     = ctrl_q[CMD_LSB +: CMD_W];
        ctrl_d[ERR_LSB +: ERR_W]     = res_err;
        ctrl_d[DONE_BIT]             = 1'b1;
        state_d                      = CS_ACK;
      end
      CS_ACK: begin
        if (wr_en && wdata[DONE_BIT] && (wdata != ctrl_q)) begin
          ctrl_d  = RDY_ONLY;
          state_d = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  assign en = wr_en || (state_q != CS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      ctrl_q  <= RDY_ONLY;
    end else if (en) begin
      state_q <= state_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign go     = (state_q == CS_EXEC);
  assign busy_o = (state_q != CS_IDLE);
  assign cmd_o  = ctrl_q[CMD_LSB +: CMD_W];
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/kc_store.sv
module kc_store
  import kc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [CMD_W-1:0]       cmd,
  input  logic [TAG_W-1:0]       stg_tag,
  input  logic [KEY_W-1:0]       stg_key,
  input  logic [AUX_W-1:0]       stg_aux,
  output logic [ERR_W-1:0]       res_err,
  input  logic [TAG_W-1:0]       lk_tag,
  output logic                   lk_hit,
  output logic [KEY_W-1:0]       lk_key,
  output logic [AUX_W-1:0]       lk_aux,
  output logic [NUM_ENTRIES-1:0] vld_o,
  output logic                   wiped_o
);
  localparam int N = NUM_ENTRIES;
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0]            vld_q, vld_d;
  logic [N-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [N-1:0][KEY_W-1:0] key_q, key_d;
  logic [N-1:0][AUX_W-1:0] aux_q, aux_d;

  logic [N-1:0] st_match, lk_match, free, sel;
  logic         hit_any, full_miss;
  logic         is_load, is_unload, is_wipe, bad;

  generate
    for (genvar g = 0; g < N; g++) begin : g_cmp
      assign st_match[g] = vld_q[g] && (tag_q[g] == stg_tag);
      assign lk_match[g] = vld_q[g] && (tag_q[g] == lk_tag);
    end
  endgenerate

  assign free      = ~vld_q;
  assign hit_any   = |st_match;
  assign full_miss = !hit_any && (free == '0);
  // lowest set bit: matching entry first, else lowest free entry
  assign sel       = hit_any ? (st_match & (~st_match + ONE)) : (free & (~free + ONE));

  assign is_load   = (cmd == CMD_LOAD);
  assign is_unload = (cmd == CMD_UNLOAD);
  assign is_wipe   = (cmd == CMD_WIPE);
  assign bad       = !(is_load || is_unload || is_wipe);

  always_comb begin
    if (bad)                       res_err = ERR_BADCMD;
    else if (is_load && full_miss) res_err = ERR_FULL;
    else                           res_err = ERR_NONE;
  end

  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    key_d = key_q;
    aux_d = aux_q;
    for (int i = 0; i < N; i++) begin
      if (is_wipe || (is_unload && st_match[i])) begin
        vld_d[i] = 1'b0;
        tag_d[i] = '0;
        key_d[i] = '0;
        aux_d[i] = '0;
      end else if (is_load && sel[i]) begin
        vld_d[i] = 1'b1;
        tag_d[i] = stg_tag;
        key_d[i] = stg_key;
        aux_d[i] = stg_aux;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      key_q <= '0;
      aux_q <= '0;
    end else if (go) begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      key_q <= key_d;
      aux_q <= aux_d;
    end
  end

  always_comb begin
    lk_hit = |lk_match;
    lk_key = '0;
    lk_aux = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        lk_key = lk_key | key_q[i];
        lk_aux = lk_aux | aux_q[i];
      end
    end
  end

  assign vld_o   = vld_q;
  assign wiped_o = (tag_q == '0) && (key_q == '0) && (aux_q == '0);
endmodule

// File: rtl/keycache_engine.sv
module keycache_engine
  import kc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [KEY_W-1:0]   lk_key,
  output logic [AUX_W-1:0]   lk_aux
);
  logic                   ctrl_sel;
  logic [WORD_W-1:0]      key_rd, tag_rd, aux_rd, ctrl_rd;
  logic [KEY_W-1:0]       stg_key;
  logic [TAG_W-1:0]       stg_tag;
  logic [AUX_W-1:0]       stg_aux;
  logic                   go, busy;
  logic [CMD_W-1:0]       cmd;
  logic [ERR_W-1:0]       res_err;
  logic [NUM_ENTRIES-1:0] vld;
  logic                   wiped;

  assign ctrl_sel = (bus_addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);

  kc_warray #(.WORDS(KEY_WORDS), .BASE(KEY_BASE), .READABLE(1'b0)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(key_rd), .flat_o(stg_key)
  );

  kc_warray #(.WORDS(TAG_WORDS), .BASE(TAG_BASE), .READABLE(1'b1)) u_tag (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(tag_rd), .flat_o(stg_tag)
  );

  kc_warray #(.WORDS(AUX_WORDS), .BASE(AUX_BASE), .READABLE(1'b1)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(aux_rd), .flat_o(stg_aux)
  );

  kc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && ctrl_sel), .wdata(bus_wdata),
    .res_err(res_err), .go(go), .busy_o(busy), .cmd_o(cmd), .ctrl_o(ctrl_rd)
  );

  kc_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd(cmd),
    .stg_tag(stg_tag), .stg_key(stg_key), .stg_aux(stg_aux), .res_err(res_err),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_key(lk_key), .lk_aux(lk_aux),
    .vld_o(vld), .wiped_o(wiped)
  );

  assign bus_rdata = ctrl_sel ? ctrl_rd : (key_rd | tag_rd | aux_rd);
endmodule

// File: rtl/kc_chk.sv
module kc_chk
  import kc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-3:0]      waddr,
  input logic                   wr_exe,
  input logic [WORD_W-1:0]      ctrl_val,
  input logic                   busy,
  input logic                   go,
  input logic [CMD_W-1:0]       cmd,
  input logic [NUM_ENTRIES-1:0] vld,
  input logic                   wiped,
  input logic                   lk_hit
);
  logic start;
  logic cmd_bad;
  assign start   = !busy && bus_wr && (waddr == CTRL_ADDR[ADDR_W-1:2]) && wr_exe;
  assign cmd_bad = (cmd != CMD_LOAD) && (cmd != CMD_UNLOAD) && (cmd != CMD_WIPE);

  // R1
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_val[RDY_BIT]);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> go ##1 (ctrl_val[DONE_BIT] && !ctrl_val[EXE_BIT]));

  // R7
  wipe_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (cmd == CMD_WIPE)) |=> ((vld == '0) && wiped));

  // R8
  badcmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_bad) |=> $stable(vld));

  // R10
  quiet_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(vld));

  // R13
  lookup_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (vld != '0));
endmodule

bind keycache_engine kc_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
  .waddr(bus_addr[kc_pkg::ADDR_W-1:2]), .wr_exe(bus_wdata[kc_pkg::EXE_BIT]),
  .ctrl_val(ctrl_rd), .busy(busy), .go(go), .cmd(cmd),
  .vld(vld), .wiped(wiped), .lk_hit(lk_hit)
);

// File: tb/sim_keycache_engine.sv
`timescale 1ns/1ps
module sim_keycache_engine;
  localparam int NENT = 4;
  localparam logic [11:0] CTRL = 12'h280;
  localparam logic [31:0] RDY  = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [159:0] lk_tag;
  logic         lk_hit;
  logic [511:0] lk_key;
  logic [255:0] lk_aux;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [31:0] val; string req; } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  keycache_engine #(.NUM_ENTRIES(NENT)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_key(lk_key), .lk_aux(lk_aux)
  );

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] mktag(int s);
    logic [159:0] t;
    for (int i = 0; i < 5; i++) t[32*i +: 32] = 32'h7100_0000 ^ 32'(s << 8) ^ 32'(i);
    return t;
  endfunction

  function automatic logic [511:0] mkkey(int s);
    logic [511:0] k;
    for (int i = 0; i < 16; i++) k[32*i +: 32] = 32'hA5A5_0000 ^ 32'(s * 256 + i * 3);
    return k;
  endfunction

  function automatic logic [255:0] mkaux(int s);
    logic [255:0] a;
    for (int i = 0; i < 8; i++) a[32*i +: 32] = 32'h3C00_0000 ^ 32'(s * 512 + i * 7);
    return a;
  endfunction

  // completion monitor: pops the scoreboard on each rising done bit
  logic prev_done;
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!rst_n) prev_done = 1'b0;
    else if (bus_addr == CTRL) begin
      if (bus_rdata[1] && !prev_done) begin
        if (sbq.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R2 unexpected completion: actual %h expected none", bus_rdata);
        end else begin
          e = sbq.pop_front();
          chk(e.req, 512'(bus_rdata), 512'(e.val));
        end
      end
      prev_done = bus_rdata[1];
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = CTRL; bus_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_addr = CTRL;
  endtask

  task automatic stage(int s_tag, int s_data);
    logic [159:0] t = mktag(s_tag);
    logic [511:0] k = mkkey(s_data);
    logic [255:0] a = mkaux(s_data);
    for (int i = 0; i < 5; i++)  wr(12'h240 + 12'(4*i), t[32*i +: 32]);
    for (int i = 0; i < 16; i++) wr(12'h200 + 12'(4*i), k[32*i +: 32]);
    for (int i = 0; i < 8; i++)  wr(12'h260 + 12'(4*i), a[32*i +: 32]);
  endtask

  task automatic lookup(int s, output logic hit, output logic [511:0] k, output logic [255:0] a);
    @(negedge clk);
    lk_tag = mktag(s);
    #1;
    hit = lk_hit; k = lk_key; a = lk_aux;
  endtask

  task automatic expect_hit(string req, int s_tag, int s_data);
    logic h; logic [511:0] k; logic [255:0] a;
    lookup(s_tag, h, k, a);
    chk({req, " hit"}, 512'(h), 512'(1));
    chk({req, " key"}, k, mkkey(s_data));
    chk({req, " aux"}, 512'(a), 512'(mkaux(s_data)));
  endtask

  task automatic expect_miss(string req, int s_tag);
    logic h; logic [511:0] k; logic [255:0] a;
    lookup(s_tag, h, k, a);
    chk({req, " miss"}, 512'(h), 512'(0));
    chk({req, " key zero"}, k, '0);
    chk({req, " aux zero"}, 512'(a), '0);
  endtask

  task automatic run_cmd(logic [3:0] code, logic [3:0] err, string req, bit ack);
    exp_t e;
    e.val = RDY | (32'(err) << 16) | (32'(code) << 2) | 32'h2;
    e.req = req;
    sbq.push_back(e);
    wr(CTRL, (32'(code) << 2) | 32'h1);
    #1 chk({req, " R2 done low after first edge"}, 512'(bus_rdata[1]), 512'(0));
    @(negedge clk);
    #1 chk({req, " R2 done on second edge"}, 512'(bus_rdata[1]), 512'(1));
    chk({req, " R2 scoreboard drained"}, 512'(sbq.size()), 512'(0));
    if (ack) begin
      wr(CTRL, 32'h2);
      #1 chk({req, " R9 ack to ready-only"}, 512'(bus_rdata), 512'(RDY));
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [511:0] k0;
    logic [255:0] a0;
    logic [159:0] t0;
    logic [31:0] cv;
    k0 = mkkey(1); a0 = mkaux(1); t0 = mktag(1);
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = CTRL; bus_wdata = '0; lk_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(CTRL, d);
    chk("R1 ctrl after reset", 512'(d), 512'(RDY));
    begin
      logic h; logic [511:0] k; logic [255:0] a;
      @(negedge clk); lk_tag = '0; #1;
      h = lk_hit; k = lk_key; a = lk_aux;
      chk("R12 zero tag misses after reset", 512'(h), 512'(0));
      chk("R13 miss data zero", k | 512'(a), '0);
    end

    // staging readback
    stage(1, 1);
    rd(12'h248, d); chk("R11 tag word 2 readback", 512'(d), 512'(t0[64 +: 32]));
    rd(12'h27C, d); chk("R11 aux word 7 readback", 512'(d), 512'(a0[224 +: 32]));
    rd(12'h200, d); chk("R11 key word 0 reads zero", 512'(d), 512'(0));
    rd(12'h23C, d); chk("R11 key word 15 reads zero", 512'(d), 512'(0));
    rd(12'h254, d); chk("R11 reserved reads zero", 512'(d), 512'(0));
    if (k0 == '0) chk("R11 key seed nonzero", 512'(1), 512'(0));

    // load and lookup
    run_cmd(4'd1, 4'd0, "R3 load tag1", 1'b1);
    expect_hit("R3 tag1", 1, 1);
    expect_miss("R13 unknown tag", 9);

    // overwrite same tag
    stage(1, 2);
    run_cmd(4'd1, 4'd0, "R4 reload tag1", 1'b1);
    expect_hit("R4 tag1 new data", 1, 2);

    // fill remaining entries
    for (int s = 2; s <= 4; s++) begin
      stage(s, s);
      run_cmd(4'd1, 4'd0, "R4 fill", 1'b1);
    end
    expect_hit("R4 tag4 present", 4, 4);

    // full cache
    stage(5, 5);
    run_cmd(4'd1, 4'd2, "R5 load into full cache", 1'b1);
    expect_miss("R5 rejected tag", 5);
    expect_hit("R5 tag2 kept", 2, 2);
    stage(3, 13);
    run_cmd(4'd1, 4'd0, "R4 overwrite while full", 1'b1);
    expect_hit("R4 tag3 updated", 3, 13);

    // unload
    stage(2, 0);
    run_cmd(4'd2, 4'd0, "R6 unload tag2", 1'b1);
    expect_miss("R6 tag2 gone", 2);
    expect_hit("R6 tag1 kept", 1, 2);
    stage(5, 5);
    run_cmd(4'd1, 4'd0, "R6 freed slot reused", 1'b1);
    expect_hit("R6 tag5 loaded", 5, 5);
    stage(8, 0);
    run_cmd(4'd2, 4'd0, "R6 unload absent tag", 1'b1);
    expect_hit("R6 tag5 kept", 5, 5);

    // invalid codes
    run_cmd(4'd0, 4'd1, "R8 code 0", 1'b1);
    run_cmd(4'd4, 4'd1, "R8 code 4", 1'b1);
    run_cmd(4'd15, 4'd1, "R8 code 15", 1'b1);
    expect_hit("R8 tag1 untouched", 1, 2);
    expect_hit("R8 tag5 untouched", 5, 5);

    // handshake corner cases
    stage(1, 7);
    run_cmd(4'd1, 4'd0, "R9 load before held completion", 1'b0);
    cv = RDY | (32'd1 << 2) | 32'h2;
    wr(CTRL, cv);
    #1 chk("R9 equal value is not an ack", 512'(bus_rdata), 512'(cv));
    wr(CTRL, (32'd3 << 2) | 32'h1);
    #1 chk("R10 start while held ignored", 512'(bus_rdata), 512'(cv));
    repeat (4) @(negedge clk);
    #1 chk("R10 no command started", 512'(bus_rdata), 512'(cv));
    expect_hit("R10 cache not wiped", 1, 7);
    wr(CTRL, (32'd3 << 2) | 32'h3);
    #1 chk("R9 ack with done set", 512'(bus_rdata), 512'(RDY));
    repeat (4) @(negedge clk);
    #1 chk("R9 ack starts nothing", 512'(bus_rdata), 512'(RDY));
    expect_hit("R9 cache intact after ack", 1, 7);

    // zeroize
    run_cmd(4'd3, 4'd0, "R7 zeroize", 1'b1);
    expect_miss("R7 tag1", 1);
    expect_miss("R7 tag3", 3);
    expect_miss("R7 tag4", 4);
    expect_miss("R7 tag5", 5);
    for (int s = 10; s <= 13; s++) begin
      stage(s, s);
      run_cmd(4'd1, 4'd0, "R7 all slots free", 1'b1);
    end
    stage(14, 14);
    run_cmd(4'd1, 4'd2, "R7 full again", 1'b1);
    expect_hit("R7 tag12", 12, 12);

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 ready during reset", 512'(bus_rdata), 512'(RDY));
    expect_miss("R12 tag10 after reset", 10);
    @(negedge clk);
    rst_n = 1'b1;
    expect_miss("R12 tag13 after release", 13);
    rd(12'h240, d); chk("R12 staging cleared", 512'(d), 512'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule